// File: doc/BRIEF.md
# Element-Strided Vector Load/Store Sequencer

The sequencer takes one vectorised load or store command and expands it into a series of per-element memory requests, one for each element from index 0 up to the vector length minus one. In strided mode the base operand is a single scalar value. Element i is then addressed at that base plus the signed byte displacement multiplied by i. The displacement counts bytes, the same unit a scalar load/store uses.

When the command marks its base operand as a vector register, the block switches to indexed (gather/scatter) addressing. For each element it names a consecutive register on a read port, takes the returned value as that element's base and adds the displacement. In the update form, every computed address is also written back to a destination register. The destination number is the 5-bit field extended by two bits, and it advances by 32 per element.

The block applies no alignment check. Each address is issued as the equivalent scalar access would compute it.

Top module: `vstride_seq`

## Requirements
- R1: After reset the block is idle: cmd_ready is 1, and req_valid, upd_valid, done and illegal are all 0.
- R2: In strided mode (cmd_base_vec=0), element i's req_addr equals cmd_base + sign-extended cmd_disp × i, modulo 2^64. Odd or unaligned addresses pass through unchanged.
- R3: A strided command with cmd_disp equal to zero raises illegal for exactly one cycle, the cycle after acceptance. It issues no request and raises no done.
- R4: In indexed mode (cmd_base_vec=1), element i drives rd_reg = (cmd_ra + i) mod 128, and req_addr = rd_data + sign-extended cmd_disp. A zero displacement is legal in this mode.
- R5: A legal command with vector length VL issues exactly VL requests, with req_idx counting 0..VL-1. The index advances only when req_valid and req_ready are both high. While the request is stalled, req_valid, req_idx and rd_reg hold.
- R6: A legal command with cmd_vl=0 issues no request and pulses done in the cycle after acceptance.
- R7: done is high for exactly the one cycle that follows the acceptance of the last element's request.
- R8: cmd_ready is high only while no element sequence is in progress. cmd_valid has no effect while cmd_ready is low.
- R9: In update form (cmd_update=1), every accepted request raises upd_valid in the same cycle. upd_data then equals req_addr, and upd_reg = (cmd_ra + 32·i) mod 128; for example, field 3 gives 3, 35, 67, 99.
- R10: Without the update form, upd_valid stays 0.
- R11: req_ew and req_store carry the command's cmd_ew and cmd_store for every element of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_base | input | 64 | Scalar base register value |
| cmd_disp | input | 16 | Signed byte displacement |
| cmd_vl | input | 8 | Vector length |
| cmd_ew | input | 2 | Element width code, passed through |
| cmd_store | input | 1 | 1 = store, 0 = load, passed through |
| cmd_base_vec | input | 1 | Base operand is a vector register (indexed mode) |
| cmd_update | input | 1 | Update form: write addresses back |
| cmd_ra | input | 5 | Encoded base register field |
| rd_reg | output | 7 | Register read for the current element's base (indexed mode) |
| rd_data | input | 64 | Value of register rd_reg, same cycle |
| req_valid | output | 1 | Element request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 64 | Effective address of the element |
| req_idx | output | 8 | Element index |
| req_ew | output | 2 | Element width code |
| req_store | output | 1 | Store flag |
| upd_valid | output | 1 | Address write-back strobe |
| upd_reg | output | 7 | Write-back destination register |
| upd_data | output | 64 | Write-back value (the element address) |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-command pulse |

## Verification
The assertions assume that req_ready and rd_data are driven to known values in every cycle after reset. They also assume that the register-file side returns rd_data in the same cycle that rd_reg is presented, so indexed addresses depend only on rd_data and the latched displacement. The stimulus drives req_ready from fixed and pseudo-random patterns, never leaving it undefined. It serves rd_data from a bench-held register array indexed by rd_reg, and it changes command inputs only at the falling edge.

// File: rtl/vstride_pkg.sv
package vstride_pkg;
    localparam int ADDR_W  = 64;
    localparam int DISP_W  = 16;
    localparam int VL_W    = 8;
    localparam int REG_W   = 5;
    localparam int REG_EXT = 2;
    localparam int REGN_W  = REG_W + REG_EXT;
    localparam int EW_W    = 2;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [DISP_W-1:0] disp;
        logic [VL_W-1:0]   vl;
        logic [EW_W-1:0]   ew;
        logic              store;
        logic              vec;
        logic              upd;
        logic [REG_W-1:0]  ra;
    } seq_cmd_t;

    function automatic logic [ADDR_W-1:0] disp_to_addr(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic cmd_is_illegal(input seq_cmd_t c);
        return (!c.vec) && (c.disp == '0);
    endfunction
endpackage

// File: rtl/vstride_ctrl.sv
module vstride_ctrl
    import vstride_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  seq_cmd_t        cmd_in,
    input  logic            req_ready,
    output logic            cmd_ready,
    output logic            running,
    output logic            start,
    output logic            step,
    output seq_cmd_t        cmd_q,
    output logic [VL_W-1:0] idx,
    output logic            done,
    output logic            illegal
);
    seq_state_e state;
    logic       take;
    logic       last;

    assign cmd_ready = (state == ST_IDLE);
    assign running   = (state == ST_RUN);
    assign take      = cmd_ready && cmd_valid;
    assign start     = take && !cmd_is_illegal(cmd_in) && (cmd_in.vl != '0);
    assign step      = running && req_ready;
    assign last      = (idx == cmd_q.vl - VL_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cmd_q   <= '0;
            idx     <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        cmd_q <= cmd_in;
                        idx   <= '0;
                        if (cmd_is_illegal(cmd_in)) begin
                            illegal <= 1'b1;
                        end else if (cmd_in.vl == '0) begin
                            done <= 1'b1;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (step) begin
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + VL_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vstride_agen.sv
module vstride_agen
    import vstride_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [ADDR_W-1:0] disp_ext,
    input  logic              indexed,
    input  logic [ADDR_W-1:0] elem_base,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (start) begin
            acc_q <= start_base;
        end else if (step) begin
            acc_q <= acc_q + disp_ext;
        end
    end

    assign addr = indexed ? (elem_base + disp_ext) : acc_q;
endmodule

// File: rtl/vstride_regmap.sv
module vstride_regmap
    import vstride_pkg::*;
(
    input  logic [REG_W-1:0]   field,
    input  logic [REGN_W-1:0]  idx_low,
    output logic [REGN_W-1:0]  src_reg,
    output logic [REGN_W-1:0]  dst_reg
);
    localparam logic [REGN_W-1:0] DST_STEP = REGN_W'(1) << REG_W;

    logic [REGN_W-1:0] field_ext;
    logic [REGN_W-1:0] dst_off;

    assign field_ext = {{REG_EXT{1'b0}}, field};

    always_comb begin
        dst_off = '0;
        for (int b = 0; b < REG_EXT; b++) begin
            if (idx_low[b]) dst_off = dst_off + (DST_STEP << b);
        end
    end

    assign src_reg = field_ext + idx_low;
    assign dst_reg = field_ext + dst_off;
endmodule

// File: rtl/vstride_seq.sv
module vstride_seq
    import vstride_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [63:0]       cmd_base,
    input  logic [15:0]       cmd_disp,
    input  logic [7:0]        cmd_vl,
    input  logic [1:0]        cmd_ew,
    input  logic              cmd_store,
    input  logic              cmd_base_vec,
    input  logic              cmd_update,
    input  logic [4:0]        cmd_ra,
    output logic [6:0]        rd_reg,
    input  logic [63:0]       rd_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [63:0]       req_addr,
    output logic [7:0]        req_idx,
    output logic [1:0]        req_ew,
    output logic              req_store,
    output logic              upd_valid,
    output logic [6:0]        upd_reg,
    output logic [63:0]       upd_data,
    output logic              done,
    output logic              illegal
);
    seq_cmd_t          cmd_in;
    seq_cmd_t          cmd_q;
    logic              running;
    logic              start;
    logic              step;
    logic [VL_W-1:0]   idx;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] addr;

    always_comb begin
        cmd_in.base  = cmd_base;
        cmd_in.disp  = cmd_disp;
        cmd_in.vl    = cmd_vl;
        cmd_in.ew    = cmd_ew;
        cmd_in.store = cmd_store;
        cmd_in.vec   = cmd_base_vec;
        cmd_in.upd   = cmd_update;
        cmd_in.ra    = cmd_ra;
    end

    vstride_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_in),
        .req_ready (req_ready),
        .cmd_ready (cmd_ready),
        .running   (running),
        .start     (start),
        .step      (step),
        .cmd_q     (cmd_q),
        .idx       (idx),
        .done      (done),
        .illegal   (illegal)
    );

    assign disp_ext = disp_to_addr(cmd_q.disp);

    vstride_agen u_agen (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .step       (step),
        .start_base (cmd_base),
        .disp_ext   (disp_ext),
        .indexed    (cmd_q.vec),
        .elem_base  (rd_data),
        .addr       (addr)
    );

    vstride_regmap u_regmap (
        .field   (cmd_q.ra),
        .idx_low (idx[REGN_W-1:0]),
        .src_reg (rd_reg),
        .dst_reg (upd_reg)
    );

    assign req_valid = running;
    assign req_addr  = addr;
    assign req_idx   = idx;
    assign req_ew    = cmd_q.ew;
    assign req_store = cmd_q.store;
    assign upd_valid = step && cmd_q.upd;
    assign upd_data  = addr;
endmodule

// File: rtl/vstride_seq_chk.sv
module vstride_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_ready,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic [7:0]  req_idx,
    input logic [6:0]  rd_reg,
    input logic        upd_valid,
    input logic [63:0] upd_data,
    input logic        done,
    input logic        illegal,
    input logic        mode_vec,
    input logic [63:0] disp_ext
);
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_idx) && $stable(rd_reg)));

    // R2
    stall_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !mode_vec) |=> $stable(req_addr));

    // R2
    stride_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !mode_vec) |=>
            (!req_valid || req_addr == $past(req_addr) + $past(disp_ext)));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_valid || req_idx == $past(req_idx) + 8'd1));

    // R3
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!req_valid && !done));

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !cmd_ready);

    // R9
    upd_match_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (req_valid && req_ready && upd_data == req_addr));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cmd_ready && !req_valid));
endmodule

bind vstride_seq vstride_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_ready (cmd_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_idx   (req_idx),
    .rd_reg    (rd_reg),
    .upd_valid (upd_valid),
    .upd_data  (upd_data),
    .done      (done),
    .illegal   (illegal),
    .mode_vec  (cmd_q.vec),
    .disp_ext  (disp_ext)
);

// File: tb/vstride_seq_test.sv
module vstride_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [63:0] cmd_base;
    logic [15:0] cmd_disp;
    logic [7:0]  cmd_vl;
    logic [1:0]  cmd_ew;
    logic        cmd_store;
    logic        cmd_base_vec;
    logic        cmd_update;
    logic [4:0]  cmd_ra;
    logic [6:0]  rd_reg;
    logic [63:0] rd_data;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic [7:0]  req_idx;
    logic [1:0]  req_ew;
    logic        req_store;
    logic        upd_valid;
    logic [6:0]  upd_reg;
    logic [63:0] upd_data;
    logic        done;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] regs [128];
    int rmode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    bit          m_run, m_done, m_ill, m_vec, m_upd, m_st;
    int          m_idx, m_vl;
    logic [63:0] m_base;
    logic [15:0] m_disp;
    logic [1:0]  m_ew;
    logic [4:0]  m_ra;
    string       m_done_tag;

    always #2 clk = ~clk;

    assign rd_data = regs[rd_reg];

    vstride_seq uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] sx(input logic [15:0] d);
        return {{48{d[15]}}, d};
    endfunction

    task automatic step();
        logic [63:0] e_addr;
        logic [6:0]  e_src, e_dst;
        bit          acc;
        #1;
        e_src  = 7'(m_ra + m_idx);
        e_dst  = 7'(m_ra + 32 * m_idx);
        e_addr = m_vec ? regs[e_src] + sx(m_disp) : m_base + sx(m_disp) * 64'(m_idx);
        chk(cmd_ready === !m_run, "R8 cmd_ready", 64'(cmd_ready), 64'(!m_run));
        chk(done === m_done, m_done_tag, 64'(done), 64'(m_done));
        chk(illegal === m_ill, "R3 illegal", 64'(illegal), 64'(m_ill));
        chk(req_valid === m_run, "R5 req_valid", 64'(req_valid), 64'(m_run));
        acc = m_run && req_ready;
        chk(upd_valid === (acc && m_upd), m_upd ? "R9 upd_valid" : "R10 upd_valid",
            64'(upd_valid), 64'(acc && m_upd));
        if (m_run) begin
            chk(req_addr === e_addr, m_vec ? "R4 req_addr" : "R2 req_addr", req_addr, e_addr);
            chk(req_idx === 8'(m_idx), "R5 req_idx", 64'(req_idx), 64'(m_idx));
            chk(req_ew === m_ew && req_store === m_st, "R11 ew/store",
                64'({req_ew, req_store}), 64'({m_ew, m_st}));
            if (m_vec) chk(rd_reg === e_src, "R4 rd_reg", 64'(rd_reg), 64'(e_src));
            if (acc && m_upd) begin
                chk(upd_reg === e_dst, "R9 upd_reg", 64'(upd_reg), 64'(e_dst));
                chk(upd_data === e_addr, "R9 upd_data", upd_data, e_addr);
            end
        end
        // advance model across the coming edge
        m_done = 0;
        m_ill  = 0;
        if (m_run) begin
            if (req_ready) begin
                m_idx++;
                if (m_idx == m_vl) begin
                    m_run = 0;
                    m_done = 1;
                    m_done_tag = "R7 done";
                end
            end
        end else if (cmd_valid) begin
            m_base = cmd_base; m_disp = cmd_disp; m_vl = int'(cmd_vl);
            m_ew = cmd_ew; m_st = cmd_store; m_vec = cmd_base_vec;
            m_upd = cmd_update; m_ra = cmd_ra; m_idx = 0;
            if (!cmd_base_vec && cmd_disp == 16'd0) m_ill = 1;
            else if (cmd_vl == 8'd0) begin
                m_done = 1;
                m_done_tag = "R6 done";
            end else m_run = 1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        case (rmode)
            0: req_ready = 1'b1;
            1: req_ready = ~req_ready;
            default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                req_ready = lfsr[0] | lfsr[3];
            end
        endcase
        step();
    endtask

    task automatic issue(input logic [63:0] b, input logic [15:0] d, input logic [7:0] vl,
                         input logic [1:0] ew, input bit st, input bit vec, input bit upd,
                         input logic [4:0] ra, input bit spam);
        cmd_base = b; cmd_disp = d; cmd_vl = vl; cmd_ew = ew; cmd_store = st;
        cmd_base_vec = vec; cmd_update = upd; cmd_ra = ra; cmd_valid = 1'b1;
        tick();
        while (m_run) begin
            cmd_valid = spam;
            if (spam) begin
                // R8: a busy-time command must not disturb the sequence
                cmd_base = 64'hDEAD_0000_BEEF_0000; cmd_disp = 16'h0000;
                cmd_vl = 8'd9; cmd_base_vec = 1'b0; cmd_update = 1'b1; cmd_ra = 5'd17;
            end
            tick();
        end
        cmd_valid = 1'b0;
        tick();
        tick();
    endtask

    initial begin
        for (int k = 0; k < 128; k++) regs[k] = 64'h0000_1000_0000_0000 + 64'(k) * 64'h0000_0000_0001_0010;
        rst = 1'b1; cmd_valid = 1'b0; req_ready = 1'b0;
        cmd_base = '0; cmd_disp = '0; cmd_vl = '0; cmd_ew = '0; cmd_store = 1'b0;
        cmd_base_vec = 1'b0; cmd_update = 1'b0; cmd_ra = '0;
        m_run = 0; m_done = 0; m_ill = 0; m_idx = 0; m_vl = 0; m_vec = 0; m_upd = 0;
        m_st = 0; m_base = '0; m_disp = '0; m_ew = '0; m_ra = '0; m_done_tag = "R7 done";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cmd_ready === 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'd1);
        chk(req_valid === 1'b0, "R1 req_valid", 64'(req_valid), 64'd0);
        chk(upd_valid === 1'b0, "R1 upd_valid", 64'(upd_valid), 64'd0);
        chk(done === 1'b0 && illegal === 1'b0, "R1 done/illegal", 64'({done, illegal}), 64'd0);
        @(negedge clk);

        rmode = 0;
        issue(64'h1000, 16'd24, 8'd6, 2'd2, 1'b0, 1'b0, 1'b0, 5'd1, 1'b0);
        issue(64'h1003, 16'd24, 8'd5, 2'd2, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0);
        issue(64'h8000, 16'hFFE8, 8'd7, 2'd3, 1'b0, 1'b0, 1'b0, 5'd2, 1'b0);
        issue(64'hFFFF_FFFF_FFFF_FFF0, 16'd8, 8'd4, 2'd3, 1'b0, 1'b0, 1'b0, 5'd2, 1'b0);
        rmode = 1;
        issue(64'h2000, 16'd64, 8'd5, 2'd3, 1'b1, 1'b0, 1'b1, 5'd3, 1'b1);
        issue(64'h0, 16'd0, 8'd4, 2'd1, 1'b0, 1'b0, 1'b1, 5'd4, 1'b0);
        issue(64'h3000, 16'd12, 8'd0, 2'd1, 1'b0, 1'b0, 1'b0, 5'd4, 1'b0);
        issue(64'h3000, 16'd0, 8'd0, 2'd1, 1'b0, 1'b1, 1'b0, 5'd4, 1'b0);
        rmode = 2;
        issue(64'h0, 16'd0, 8'd6, 2'd2, 1'b0, 1'b1, 1'b1, 5'd30, 1'b0);
        issue(64'h0, 16'hFFFC, 8'd9, 2'd0, 1'b1, 1'b1, 1'b0, 5'd7, 1'b1);
        issue(64'h4000_0000, 16'h7FFF, 8'd255, 2'd0, 1'b0, 1'b0, 1'b1, 5'd31, 1'b0);
        issue(64'h5000, 16'd1, 8'd1, 2'd1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0);
        rmode = 0;
        issue(64'h6000, 16'd16, 8'd3, 2'd2, 1'b0, 1'b0, 1'b1, 5'd5, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule